// File: doc/BRIEF.md
# I2C Byte Register Slave with Bus Watchdog

This block is a slave on a two-wire serial bus. It holds a small file of byte registers behind one fixed 7-bit device address. A fast system clock oversamples both bus lines. SDA is driven open-drain style: the block only ever pulls the line low through an enable, and it leaves the high level to the external pull-up. The block recognises the framing edges that start and stop a transfer. It decodes the address byte, which ends in a direction bit. In a write, the first data byte sets an internal pointer and every later byte is stored at that pointer. In a read, the bytes sent go out from that same pointer.

The pointer steps forward after every stored or transmitted byte. It keeps its value from one transaction to the next, so a write that carries only the pointer, followed by a read, reads back from that location. If SCL stays low for too long, a watchdog returns the slave to idle. From then on the slave ignores all traffic until it sees a fresh START. A second port on the host side reads any register combinationally.

Top module: `i2c_regslave`

## Requirements
- R1: After reset every register reads 0x00 on the host port, the pointer is 0x00 and SDA is released.
- R2: SDA falling while SCL is high is a START. SDA rising while SCL is high is a STOP. After a STOP the slave releases SDA and stays idle until the next START.
- R3: The first byte after a START is sent MSB first. Its upper seven bits are compared with DEV_ADDR (default 7'h68), and bit 0 gives the direction (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock.
- R4: A byte whose address does not match gets no acknowledge. SDA stays released and no register changes until the next START or STOP.
- R5: In a write, the first data byte loads the pointer. Each later byte is stored at the pointer, after which the pointer increments. Every byte is acknowledged.
- R6: In a read, the slave sends the byte at the pointer MSB first and then increments the pointer. It sends the next byte after a master ACK (SDA low on the ninth clock). After a NACK it releases SDA and waits for a START or STOP.
- R7: The pointer wraps from NUM_REGS-1 (0x10 by default) to 0x00. Any other value counts up modulo 256. The pointer keeps its value across transactions.
- R8: A byte written while the pointer is at NUM_REGS or above is acknowledged but discarded. Reads at such a pointer return 0x00, on the bus and on the host port.
- R9: A STOP or START that comes in the middle of a byte drops that byte without writing it. A repeated START begins a new address phase at once.
- R10: If SCL stays low for TIMEOUT_CYC system cycles while a transfer is active, the slave releases SDA and returns to idle. After that it acknowledges nothing until a new START.
- R11: The slave starts pulling SDA low only while the synchronised SCL is low. It stops pulling only while SCL is low or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level (wired line) |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| host_raddr | input | 8 | Host-side register read address |
| host_rdata | output | 8 | Register contents at host_raddr, 0x00 when out of range |

## Verification
Line changes reach the control logic two synchroniser flops and one edge flop later, so the slave's SDA response follows an SCL edge by about three system cycles. The bench holds each quarter of a bit period for ten cycles and reads SDA halfway through the SCL high phase, well after any response has settled. Host port reads are combinational and are checked one cycle after the address is set. The watchdog is tested by holding SCL low for three times the limit before any check.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
   localparam int BYTE_W = 8;
   localparam int BCNT_W = $clog2(BYTE_W + 1);

   typedef logic [BYTE_W-1:0] byte_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK,
      ST_WRX,
      ST_WACK,
      ST_RTX,
      ST_RACK
   } rs_state_t;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NSIG = 2;

   logic [NSIG-1:0] raw_vec;
   logic [NSIG-1:0] syn_vec;
   logic [NSIG-1:0] prv_vec;

   assign raw_vec = {sda_i, scl_i};

   genvar g;
   generate
      for (g = 0; g < NSIG; g++) begin : g_line
         logic [STAGES-1:0] pipe;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw_vec[g]};
         end
         assign syn_vec[g] = pipe[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prv_vec <= '1;
      else        prv_vec <= syn_vec;
   end

   assign scl_s     = syn_vec[0];
   assign sda_s     = syn_vec[1];
   assign scl_rise  =  syn_vec[0] & ~prv_vec[0];
   assign scl_fall  = ~syn_vec[0] &  prv_vec[0];
   assign start_det =  syn_vec[0] &  prv_vec[0] & prv_vec[1] & ~syn_vec[1];
   assign stop_det  =  syn_vec[0] &  prv_vec[0] & ~prv_vec[1] & syn_vec[1];
endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile #(
   parameter int NUM_REGS = 17,
   parameter int AW       = 8,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   logic [DW-1:0] mem [NUM_REGS];

   genvar i;
   generate
      for (i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[i] <= '0;
            else if (we && waddr == AW'(i))      mem[i] <= wdata;
         end
      end
   endgenerate

   always_comb begin
      rdata_a = '0;
      rdata_b = '0;
      for (int k = 0; k < NUM_REGS; k++) begin
         if (raddr_a == AW'(k)) rdata_a = mem[k];
         if (raddr_b == AW'(k)) rdata_b = mem[k];
      end
   end
endmodule

// File: rtl/i2c_rs_timeout.sv
module i2c_rs_timeout #(
   parameter int LIMIT = 3500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic armed,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (scl_s || !armed) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
   end

   assign expire = armed && !scl_s && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/i2c_rs_ctrl.sv
module i2c_rs_ctrl
   import i2c_rs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h68,
   parameter int         NUM_REGS = 17
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sda_s,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_det,
   input  logic  stop_det,
   input  logic  timeout,
   input  byte_t rd_data,
   output byte_t rd_addr,
   output logic  we,
   output byte_t waddr,
   output byte_t wdata,
   output logic  sda_oe,
   output logic  armed
);
   localparam byte_t LAST = byte_t'(NUM_REGS - 1);

   rs_state_t         state;
   logic [BCNT_W-1:0] bitcnt;
   byte_t             shreg;
   byte_t             tx;
   byte_t             ptr;
   logic              ptr_phase;
   logic              rw;
   logic              mack;
   byte_t             ptr_nxt;
   logic              byte_end;

   assign ptr_nxt  = (ptr == LAST) ? '0 : ptr + 1'b1;
   assign byte_end = scl_fall && (bitcnt == BCNT_W'(BYTE_W));
   assign armed    = (state != ST_IDLE);
   assign rd_addr  = ptr;
   assign waddr    = ptr;
   assign wdata    = shreg;
   assign we       = (state == ST_WRX) && byte_end && !ptr_phase &&
                     !timeout && !start_det && !stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         tx        <= '0;
         ptr       <= '0;
         ptr_phase <= 1'b0;
         rw        <= 1'b0;
         mack      <= 1'b0;
         sda_oe    <= 1'b0;
      end else if (timeout) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         bitcnt    <= '0;
         ptr_phase <= 1'b1;
         sda_oe    <= 1'b0;
      end else if (stop_det) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         unique case (state)
            ST_ADDR: begin
               if (scl_rise) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  bitcnt <= '0;
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                     rw     <= shreg[0];
                     sda_oe <= 1'b1;
                     state  <= ST_AACK;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            ST_AACK: begin
               if (scl_fall) begin
                  bitcnt <= '0;
                  if (rw) begin
                     tx     <= {rd_data[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~rd_data[BYTE_W-1];
                     state  <= ST_RTX;
                  end else begin
                     sda_oe <= 1'b0;
                     state  <= ST_WRX;
                  end
               end
            end
            ST_WRX: begin
               if (scl_rise) begin
                  shreg  <= {shreg[BYTE_W-2:0], sda_s};
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  bitcnt <= '0;
                  sda_oe <= 1'b1;
                  state  <= ST_WACK;
                  if (ptr_phase) begin
                     ptr       <= shreg;
                     ptr_phase <= 1'b0;
                  end else begin
                     ptr <= ptr_nxt;
                  end
               end
            end
            ST_WACK: begin
               if (scl_fall) begin
                  sda_oe <= 1'b0;
                  state  <= ST_WRX;
               end
            end
            ST_RTX: begin
               if (scl_rise) begin
                  bitcnt <= bitcnt + 1'b1;
               end else if (byte_end) begin
                  bitcnt <= '0;
                  sda_oe <= 1'b0;
                  ptr    <= ptr_nxt;
                  state  <= ST_RACK;
               end else if (scl_fall) begin
                  sda_oe <= ~tx[BYTE_W-1];
                  tx     <= {tx[BYTE_W-2:0], 1'b0};
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  mack <= ~sda_s;
               end else if (scl_fall) begin
                  if (mack) begin
                     tx     <= {rd_data[BYTE_W-2:0], 1'b0};
                     sda_oe <= ~rd_data[BYTE_W-1];
                     state  <= ST_RTX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
   import i2c_rs_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h68,
   parameter int         NUM_REGS    = 17,
   parameter int         SYNC_STAGES = 2,
   parameter int         TIMEOUT_CYC = 3500000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [BYTE_W-1:0] host_raddr,
   output logic [BYTE_W-1:0] host_rdata
);
   generate
      if (NUM_REGS < 1 || NUM_REGS > 256) begin : g_bad_regs
         $error("NUM_REGS must lie in 1..256");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (TIMEOUT_CYC < 16) begin : g_bad_to
         $error("TIMEOUT_CYC must be at least 16");
      end
   endgenerate

   logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic  timeout, armed, we;
   byte_t rd_addr, rd_data, waddr, wdata;

   i2c_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_rs_timeout #(.LIMIT(TIMEOUT_CYC)) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_s  (scl_s),
      .armed  (armed),
      .expire (timeout)
   );

   i2c_rs_ctrl #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .timeout   (timeout),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .we        (we),
      .waddr     (waddr),
      .wdata     (wdata),
      .sda_oe    (sda_oe),
      .armed     (armed)
   );

   i2c_rs_regfile #(.NUM_REGS(NUM_REGS), .AW(BYTE_W), .DW(BYTE_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata),
      .raddr_a (rd_addr),
      .rdata_a (rd_data),
      .raddr_b (host_raddr),
      .rdata_b (host_rdata)
   );
endmodule

// File: rtl/i2c_rs_chk.sv
module i2c_rs_chk #(
   parameter int TIMEOUT_CYC = 3500000
) (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic sda_oe
);
   localparam int LOWMAX = TIMEOUT_CYC + 2;
   localparam int CW     = $clog2(LOWMAX + 1);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_cnt <= '0;
      else if (scl_s)                   low_cnt <= '0;
      else if (low_cnt != CW'(LOWMAX))  low_cnt <= low_cnt + 1'b1;
   end

   assert_oe_rise_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> $past(!scl_s));

   assert_oe_fall_ok_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

   assert_stop_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   assert_start_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   assert_timeout_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt == CW'(LOWMAX)) |-> !sda_oe);
endmodule

bind i2c_regslave i2c_rs_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe)
);

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;
   localparam int        NREG = 17;
   localparam int        TO   = 200;
   localparam int        Q    = 10;
   localparam logic [6:0] DA  = 7'h68;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe;
   logic [7:0] host_raddr = '0;
   logic [7:0] host_rdata;
   wire  sda_line = m_sda & ~sda_oe;

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] mdl [NREG];

   always #2 clk = ~clk;

   i2c_regslave #(.DEV_ADDR(DA), .NUM_REGS(NREG), .TIMEOUT_CYC(TO)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (m_scl),
      .sda_i      (sda_line),
      .sda_oe     (sda_oe),
      .host_raddr (host_raddr),
      .host_rdata (host_rdata)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; hold(Q);
      m_scl = 1'b1; hold(Q);
      m_sda = 1'b0; hold(Q);
      m_scl = 1'b0; hold(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; hold(Q);
      m_scl = 1'b1; hold(Q);
      m_sda = 1'b1; hold(Q);
   endtask

   task automatic clk_bit(input logic b, output logic seen);
      m_sda = b;    hold(Q);
      m_scl = 1'b1; hold(Q);
      seen = sda_line;
      hold(Q);
      m_scl = 1'b0; hold(Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
      clk_bit(1'b1, s);
      ack = ~s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      clk_bit(~give_ack, s);
   endtask

   task automatic check_regs(input string req);
      for (int i = 0; i < NREG + 3; i++) begin
         host_raddr = 8'(i);
         hold(1);
         chk(req, $sformatf("host reg %0d", i), int'(host_rdata),
             (i < NREG) ? int'(mdl[i]) : 0);
      end
   endtask

   function automatic logic [7:0] pat(input int k);
      return 8'((k * 29 + 7) & 8'hFF);
   endfunction

   initial begin
      logic ack;
      logic [7:0] d;
      int p;
      for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
      hold(5);
      // R1: reset state
      chk("R1", "sda_oe in reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      hold(5);
      chk("R1", "sda_oe after reset", int'(sda_oe), 0);
      check_regs("R1");

      // R1: pointer is zero after reset, read without pointer write
      bus_start();
      send_byte({DA, 1'b1}, ack);
      chk("R3", "read address ack", int'(ack), 1);
      recv_byte(1'b0, d);
      chk("R1", "first read at reset pointer", int'(d), 0);
      chk("R6", "released after nack", int'(sda_oe), 0);
      bus_stop();

      // R5/R7: sweep all registers plus two wrapped bytes
      bus_start();
      send_byte({DA, 1'b0}, ack);
      chk("R3", "write address ack", int'(ack), 1);
      send_byte(8'h00, ack);
      chk("R5", "pointer byte ack", int'(ack), 1);
      for (int k = 0; k < NREG + 2; k++) begin
         send_byte(pat(k), ack);
         chk("R5", $sformatf("data byte %0d ack", k), int'(ack), 1);
         mdl[k % NREG] = pat(k);
      end
      bus_stop();
      chk("R2", "released after stop", int'(sda_oe), 0);
      check_regs("R7");

      // R6/R7/R9: pointer-only write, repeated START, read across wrap
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'(NREG - 2), ack);
      chk("R7", "pointer ack near end", int'(ack), 1);
      bus_start();
      send_byte({DA, 1'b1}, ack);
      chk("R9", "address after repeated START", int'(ack), 1);
      for (int k = 0; k < 5; k++) begin
         recv_byte(k != 4, d);
         p = (NREG - 2 + k) % NREG;
         chk("R6", $sformatf("read byte %0d", k), int'(d), int'(mdl[p]));
      end
      chk("R6", "SDA released after nack", int'(sda_oe), 0);
      bus_stop();

      // R7: pointer persists; read continues where previous read stopped (index 3)
      bus_start();
      send_byte({DA, 1'b1}, ack);
      recv_byte(1'b0, d);
      chk("R7", "pointer kept across transactions", int'(d), int'(mdl[3]));
      bus_stop();

      // R4: non-matching addresses
      for (int a = 0; a < 3; a++) begin
         logic [6:0] bad;
         bad = (a == 0) ? 7'h69 : (a == 1) ? 7'h28 : 7'h48;
         bus_start();
         send_byte({bad, 1'b0}, ack);
         chk("R4", $sformatf("no ack for %0h", bad), int'(ack), 0);
         send_byte(8'h02, ack);
         chk("R4", "no ack on following byte", int'(ack), 0);
         send_byte(8'hEE, ack);
         chk("R4", "no ack on data byte", int'(ack), 0);
         bus_stop();
      end
      check_regs("R4");

      // R8: out-of-range writes acked and dropped, reads return zero
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'h20, ack);
      send_byte(8'hAA, ack);
      chk("R8", "out-of-range write ack", int'(ack), 1);
      send_byte(8'h55, ack);
      chk("R8", "second out-of-range write ack", int'(ack), 1);
      bus_stop();
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'h30, ack);
      bus_start();
      send_byte({DA, 1'b1}, ack);
      recv_byte(1'b1, d);
      chk("R8", "out-of-range read 0x30", int'(d), 0);
      recv_byte(1'b0, d);
      chk("R8", "out-of-range read 0x31", int'(d), 0);
      bus_stop();
      check_regs("R8");

      // R9: partial byte aborted by STOP
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'h03, ack);
      for (int i = 0; i < 4; i++) clk_bit(1'b1, ack);
      bus_stop();
      // R9: partial byte aborted by repeated START, new address phase works
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'h03, ack);
      for (int i = 0; i < 5; i++) clk_bit(1'b0, ack);
      bus_start();
      send_byte({DA, 1'b0}, ack);
      chk("R9", "address ack after mid-byte START", int'(ack), 1);
      send_byte(8'h04, ack);
      send_byte(8'h5A, ack);
      mdl[4] = 8'h5A;
      bus_stop();
      check_regs("R9");

      // R10: SCL held low beyond the limit
      bus_start();
      send_byte({DA, 1'b0}, ack);
      send_byte(8'h05, ack);
      chk("R10", "pointer ack before stall", int'(ack), 1);
      hold(3 * TO);
      chk("R10", "released after stall", int'(sda_oe), 0);
      send_byte(8'h99, ack);
      chk("R10", "no ack after timeout", int'(ack), 0);
      send_byte(8'h77, ack);
      chk("R10", "still ignoring without START", int'(ack), 0);
      bus_stop();
      host_raddr = 8'h05;
      hold(1);
      chk("R10", "reg 5 untouched", int'(host_rdata), int'(mdl[5]));
      bus_start();
      send_byte({DA, 1'b0}, ack);
      chk("R10", "fresh START accepted", int'(ack), 1);
      send_byte(8'h05, ack);
      send_byte(8'hC3, ack);
      mdl[5] = 8'hC3;
      bus_stop();
      check_regs("R10");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end
endmodule